// File: doc/BRIEF.md
# Serial Flash Feature Register Unit

This block is the register file on the device side of a serial NAND-style memory. An SPI command decoder sits in front of it and passes in opcodes, the feature address byte and data bytes. The unit holds four byte-wide registers: block protection, configuration, status and output drive strength. It answers get-features reads and set-features writes. It also keeps the write-enable latch and applies hardware write protection using the write-protect pin.

Status comes from an array controller that is not part of this block. That controller reports busy, program and erase failures, ECC results and the completion of operations that modify the array. The configuration fields are exported as plain outputs so that the rest of the memory can use them.

Transactions are framed by `cs_n`. While `cs_n` is low, the decoder presents:
- one opcode on `cmd_valid`;
- then, for get-features or set-features, one address byte on `addr_valid`;
- then, for set-features, data on `wr_valid`.

The write data channel uses valid/ready. A byte transfers only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is high for exactly one byte per set-features transaction. A byte offered while `wr_ready` is low is discarded; it is not held. The read side has no back-pressure. `rd_data` is a level that the shifter may sample on any cycle while `rd_valid` is high.

Top module: `nand_feature_regfile`

## Requirements
- R1: After reset, the four registers read as follows:
  - address A0h (protection): 00h
  - address B0h (configuration): 10h, with the ECC enable bit at bit 4 set
  - address C0h (status): 00h while not busy
  - address D0h (drive): 00h
- R2: Only the addresses A0h, B0h, C0h and D0h are decoded. A set-features write to any other address changes no register, and a get-features read of any other address returns 00h.
- R3: A get-features transaction is opcode 0Fh followed by an address byte.
  - `rd_valid` rises in the cycle after the address byte is accepted.
  - `rd_data` follows the live register value, including the busy bit (status bit 0), for as long as `cs_n` stays low.
  - `rd_valid` is low in the cycle after `cs_n` goes high.
- R4: A set-features transaction is opcode 1Fh, then an address byte, then data.
  - Only the first data byte that transfers is written, and it takes effect from the next cycle.
  - After that byte, `wr_ready` is low, so later bytes in the same transaction are ignored.
  - Reserved bits always read back as 0. Writable bits are: protection mask BEh, configuration mask D1h, drive mask 60h.
- R5: The status register at C0h is read-only. A set-features write to C0h leaves every status bit unchanged.
- R6: The protection lock bit is bit 7 of A0h. When it is 1 and `wp_n` is low, writes to A0h are ignored. In every other combination, writes to A0h go through.
- R7: Opcode 06h sets the write-enable latch and opcode 04h clears it. The latch is visible as status bit 1 and on the `wel` output.
- R8: An `op_done` pulse clears the write-enable latch. If `op_done` and opcode 06h arrive in the same cycle, the clear wins.
- R9: Opcode FFh (soft reset) always clears the write-enable latch.
  - When `array_busy` is low, it also clears the ECC code and both fail flags.
  - When `array_busy` is high, the ECC code and both fail flags are kept.
  - The protection, configuration and drive registers are never changed by a soft reset.
- R10: Status bit layout and sources:
  - `pfail_set` sets bit 3 and `efail_set` sets bit 2. Both stay set until cleared.
  - `ecc_valid` loads `ecc_code` into bits 6..4.
  - Bit 0 follows `array_busy` in the same cycle.
- R11: The exported fields match the stored bits:
  - `prot_bp` is A0h[5:3], `prot_inv` is A0h[2] and `prot_cmp` is A0h[1].
  - `cfg_otp_prt` is B0h[7], `cfg_otp_en` is B0h[6], `cfg_ecc_en` is B0h[4] and `cfg_qe` is B0h[0].
  - `drive_str` is D0h[6:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high ends the transaction |
| cmd_valid | input | 1 | Opcode strobe |
| cmd_op | input | 8 | Opcode |
| addr_valid | input | 1 | Feature address strobe |
| addr_byte | input | 8 | Feature address |
| wr_valid | input | 1 | Set-features data valid |
| wr_data | input | 8 | Set-features data |
| wr_ready | output | 1 | Set-features data accepted this cycle |
| rd_valid | output | 1 | Get-features data present |
| rd_data | output | 8 | Live value of the selected register |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| array_busy | input | 1 | Array operation in progress |
| op_done | input | 1 | Program, OTP program or erase finished |
| pfail_set | input | 1 | Program failure pulse |
| efail_set | input | 1 | Erase failure pulse |
| ecc_valid | input | 1 | ECC result strobe |
| ecc_code | input | 3 | ECC result code |
| wel | output | 1 | Write-enable latch |
| prot_bp | output | 3 | Block protect field |
| prot_inv | output | 1 | Protect invert bit |
| prot_cmp | output | 1 | Protect complement bit |
| cfg_otp_prt | output | 1 | OTP protect bit |
| cfg_otp_en | output | 1 | OTP access enable |
| cfg_ecc_en | output | 1 | Internal ECC enable |
| cfg_qe | output | 1 | Quad enable |
| drive_str | output | 2 | Output drive strength |

## Verification
The assertions assume the following about the decoder's sequencing:
- There is at most one opcode per low period of `cs_n`.
- Address and data strobes come only after the opcode.
- Event pulses from the array side last a single cycle.

The stimulus tasks build every transaction in that order and always return `cs_n` high between transactions. Array events are raised for exactly one cycle, sometimes together with an opcode, to exercise the priorities. The status-stability property is checked only in cycles where no array event or latch command coincides with a write to C0h. This is why the bench issues that write with every array input quiet.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
  localparam int BYTE_W = 8;
  localparam int ECC_W  = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OP_GET  = 8'h0F;
  localparam byte_t OP_SET  = 8'h1F;
  localparam byte_t OP_WEN  = 8'h06;
  localparam byte_t OP_WDIS = 8'h04;
  localparam byte_t OP_SRST = 8'hFF;

  localparam byte_t FA_PROT = 8'hA0;
  localparam byte_t FA_CFG  = 8'hB0;
  localparam byte_t FA_STAT = 8'hC0;
  localparam byte_t FA_DRV  = 8'hD0;

  localparam byte_t WM_PROT = 8'hBE;
  localparam byte_t WM_CFG  = 8'hD1;
  localparam byte_t WM_DRV  = 8'h60;

  localparam byte_t RV_PROT = 8'h00;
  localparam byte_t RV_CFG  = 8'h10;
  localparam byte_t RV_DRV  = 8'h00;

  localparam int LOCK_BIT = 7;

  typedef enum logic [1:0] {SES_IDLE, SES_GET, SES_SET} ses_e;
endpackage

// File: rtl/nfr_cmd_track.sv
module nfr_cmd_track
  import nfr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  cmd_valid,
  input  byte_t cmd_op,
  input  logic  addr_valid,
  input  byte_t addr_byte,
  input  logic  wr_valid,
  output byte_t sel_addr,
  output logic  get_active,
  output logic  wr_ready,
  output logic  wr_fire,
  output logic  wel_set,
  output logic  wel_clr,
  output logic  soft_rst
);
  ses_e ses_q;
  logic addr_ok_q;
  logic data_done_q;
  logic cmd_hit;

  assign cmd_hit    = !cs_n && cmd_valid;
  assign wel_set    = cmd_hit && (cmd_op == OP_WEN);
  assign wel_clr    = cmd_hit && (cmd_op == OP_WDIS);
  assign soft_rst   = cmd_hit && (cmd_op == OP_SRST);
  assign wr_ready   = !cs_n && (ses_q == SES_SET) && addr_ok_q && !data_done_q;
  assign wr_fire    = wr_valid && wr_ready;
  assign get_active = !cs_n && (ses_q == SES_GET) && addr_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ses_q       <= SES_IDLE;
      sel_addr    <= '0;
      addr_ok_q   <= 1'b0;
      data_done_q <= 1'b0;
    end else if (cs_n) begin
      ses_q       <= SES_IDLE;
      addr_ok_q   <= 1'b0;
      data_done_q <= 1'b0;
    end else if (cmd_valid) begin
      addr_ok_q   <= 1'b0;
      data_done_q <= 1'b0;
      case (cmd_op)
        OP_GET:  ses_q <= SES_GET;
        OP_SET:  ses_q <= SES_SET;
        default: ses_q <= SES_IDLE;
      endcase
    end else begin
      if (addr_valid && (ses_q != SES_IDLE) && !addr_ok_q) begin
        sel_addr  <= addr_byte;
        addr_ok_q <= 1'b1;
      end
      if (wr_fire) data_done_q <= 1'b1;
    end
  end

  // R4
  one_byte_per_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_ready);

  // R3
  read_ends_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !get_active);
endmodule

// File: rtl/nfr_store.sv
module nfr_store
  import nfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  byte_t            wr_addr,
  input  byte_t            wr_data,
  input  logic             wp_n,
  input  logic             wel_set,
  input  logic             wel_clr,
  input  logic             soft_rst,
  input  logic             op_done,
  input  logic             busy,
  input  logic             pfail_set,
  input  logic             efail_set,
  input  logic             ecc_valid,
  input  logic [ECC_W-1:0] ecc_code,
  output byte_t            prot_q,
  output byte_t            cfg_q,
  output byte_t            drv_q,
  output byte_t            stat_q
);
  logic [ECC_W-1:0] eccs_q;
  logic pfail_q, efail_q, wel_q;
  logic prot_locked;
  logic stat_clear;

  assign prot_locked = prot_q[LOCK_BIT] && !wp_n;
  assign stat_clear  = soft_rst && !busy;
  assign stat_q      = {1'b0, eccs_q, pfail_q, efail_q, wel_q, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= RV_PROT;
      cfg_q  <= RV_CFG;
      drv_q  <= RV_DRV;
    end else if (wr_fire) begin
      case (wr_addr)
        FA_PROT: if (!prot_locked) prot_q <= wr_data & WM_PROT;
        FA_CFG:  cfg_q <= wr_data & WM_CFG;
        FA_DRV:  drv_q <= wr_data & WM_DRV;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eccs_q  <= '0;
      pfail_q <= 1'b0;
      efail_q <= 1'b0;
    end else if (stat_clear) begin
      eccs_q  <= '0;
      pfail_q <= 1'b0;
      efail_q <= 1'b0;
    end else begin
      if (ecc_valid) eccs_q  <= ecc_code;
      if (pfail_set) pfail_q <= 1'b1;
      if (efail_set) efail_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             wel_q <= 1'b0;
    else if (wel_clr || op_done || soft_rst) wel_q <= 1'b0;
    else if (wel_set)                        wel_q <= 1'b1;
  end

  // R6
  prot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == FA_PROT && prot_q[LOCK_BIT] && !wp_n) |=> $stable(prot_q));

  // R5
  stat_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == FA_STAT && !pfail_set && !efail_set && !ecc_valid &&
     !soft_rst && !wel_set && !wel_clr && !op_done) |=> $stable(stat_q[7:1]));

  // R8
  done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !stat_q[1]);

  // R9
  idle_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !busy) |=> (stat_q[6:1] == '0));
endmodule

// File: rtl/nand_feature_regfile.sv
module nand_feature_regfile
  import nfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic        addr_valid,
  input  logic [7:0]  addr_byte,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  output logic        wr_ready,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  input  logic        wp_n,
  input  logic        array_busy,
  input  logic        op_done,
  input  logic        pfail_set,
  input  logic        efail_set,
  input  logic        ecc_valid,
  input  logic [2:0]  ecc_code,
  output logic        wel,
  output logic [2:0]  prot_bp,
  output logic        prot_inv,
  output logic        prot_cmp,
  output logic        cfg_otp_prt,
  output logic        cfg_otp_en,
  output logic        cfg_ecc_en,
  output logic        cfg_qe,
  output logic [1:0]  drive_str
);
  byte_t sel_addr;
  logic  get_active, wr_fire, wel_set, wel_clr, soft_rst;
  byte_t prot_q, cfg_q, drv_q, stat_q;
  byte_t rd_mux;

  nfr_cmd_track u_track (
    .clk, .rst_n, .cs_n, .cmd_valid, .cmd_op, .addr_valid, .addr_byte,
    .wr_valid, .sel_addr, .get_active, .wr_ready, .wr_fire,
    .wel_set, .wel_clr, .soft_rst
  );

  nfr_store u_store (
    .clk, .rst_n, .wr_fire, .wr_addr(sel_addr), .wr_data, .wp_n,
    .wel_set, .wel_clr, .soft_rst, .op_done, .busy(array_busy),
    .pfail_set, .efail_set, .ecc_valid, .ecc_code,
    .prot_q, .cfg_q, .drv_q, .stat_q
  );

  always_comb begin
    case (sel_addr)
      FA_PROT: rd_mux = prot_q;
      FA_CFG:  rd_mux = cfg_q;
      FA_STAT: rd_mux = stat_q;
      FA_DRV:  rd_mux = drv_q;
      default: rd_mux = '0;
    endcase
  end

  assign rd_valid    = get_active;
  assign rd_data     = get_active ? rd_mux : '0;
  assign wel         = stat_q[1];
  assign prot_bp     = prot_q[5:3];
  assign prot_inv    = prot_q[2];
  assign prot_cmp    = prot_q[1];
  assign cfg_otp_prt = cfg_q[7];
  assign cfg_otp_en  = cfg_q[6];
  assign cfg_ecc_en  = cfg_q[4];
  assign cfg_qe      = cfg_q[0];
  assign drive_str   = drv_q[6:5];

  // R4
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && sel_addr == FA_CFG) |-> ((rd_data & ~WM_CFG) == '0));

  // R3
  busy_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && sel_addr == FA_STAT) |-> (rd_data[0] == array_busy));
endmodule

// File: tb/nand_feature_regfile_bench.sv
module nand_feature_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, cmd_valid = 1'b0, addr_valid = 1'b0, wr_valid = 1'b0;
  logic [7:0] cmd_op = '0, addr_byte = '0, wr_data = '0;
  logic wp_n = 1'b1, array_busy = 1'b0, op_done = 1'b0;
  logic pfail_set = 1'b0, efail_set = 1'b0, ecc_valid = 1'b0;
  logic [2:0] ecc_code = '0;
  logic wr_ready, rd_valid, wel, prot_inv, prot_cmp;
  logic cfg_otp_prt, cfg_otp_en, cfg_ecc_en, cfg_qe;
  logic [7:0] rd_data;
  logic [2:0] prot_bp;
  logic [1:0] drive_str;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  nand_feature_regfile u_nand_feature_regfile (
    .clk, .rst_n, .cs_n, .cmd_valid, .cmd_op, .addr_valid, .addr_byte,
    .wr_valid, .wr_data, .wr_ready, .rd_valid, .rd_data, .wp_n, .array_busy,
    .op_done, .pfail_set, .efail_set, .ecc_valid, .ecc_code, .wel, .prot_bp,
    .prot_inv, .prot_cmp, .cfg_otp_prt, .cfg_otp_en, .cfg_ecc_en, .cfg_qe,
    .drive_str
  );

  // behavioural reference model
  logic [7:0] m_prot, m_cfg, m_drv, m_addr;
  logic [2:0] m_eccs;
  logic m_pf, m_ef, m_wel, m_aok, m_done;
  int m_ses;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'hA0) return m_prot;
    if (a == 8'hB0) return m_cfg;
    if (a == 8'hC0) return {1'b0, m_eccs, m_pf, m_ef, m_wel, array_busy};
    if (a == 8'hD0) return m_drv;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    logic fire;
    if (!rst_n) begin
      m_prot = 8'h00; m_cfg = 8'h10; m_drv = 8'h00; m_addr = 8'h00;
      m_eccs = 3'd0; m_pf = 0; m_ef = 0; m_wel = 0; m_aok = 0; m_done = 0;
      m_ses = 0;
    end else begin
      fire = !cs_n && m_ses == 2 && m_aok && !m_done && wr_valid;
      if (fire) begin
        if (m_addr == 8'hA0 && !(m_prot[7] && !wp_n)) m_prot = wr_data & 8'hBE;
        if (m_addr == 8'hB0) m_cfg = wr_data & 8'hD1;
        if (m_addr == 8'hD0) m_drv = wr_data & 8'h60;
      end
      if (ecc_valid) m_eccs = ecc_code;
      if (pfail_set) m_pf = 1;
      if (efail_set) m_ef = 1;
      if (!cs_n && cmd_valid && cmd_op == 8'hFF && !array_busy) begin
        m_eccs = 0; m_pf = 0; m_ef = 0;
      end
      if (!cs_n && cmd_valid && cmd_op == 8'h06) m_wel = 1;
      if (op_done || (!cs_n && cmd_valid && (cmd_op == 8'h04 || cmd_op == 8'hFF)))
        m_wel = 0;
      if (cs_n) begin
        m_ses = 0; m_aok = 0; m_done = 0;
      end else if (cmd_valid) begin
        m_ses = (cmd_op == 8'h0F) ? 1 : (cmd_op == 8'h1F) ? 2 : 0;
        m_aok = 0; m_done = 0;
      end else begin
        if (addr_valid && m_ses != 0 && !m_aok) begin
          m_addr = addr_byte; m_aok = 1;
        end
        if (fire) m_done = 1;
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_rv;
      exp_rv = !cs_n && m_ses == 1 && m_aok;
      check("R3 model rd_valid", {7'd0, rd_valid}, {7'd0, exp_rv});
      if (exp_rv) check("R3 model rd_data", rd_data, m_read(m_addr));
      check("R4 model wr_ready", {7'd0, wr_ready},
            {7'd0, !cs_n && m_ses == 2 && m_aok && !m_done});
      check("R7 model wel", {7'd0, wel}, {7'd0, m_wel});
      check("R11 model prot", {prot_bp, prot_inv, prot_cmp}, m_prot[5:1]);
      check("R11 model cfg", {cfg_otp_prt, cfg_otp_en, cfg_ecc_en, cfg_qe},
            {m_cfg[7], m_cfg[6], m_cfg[4], m_cfg[0]});
      check("R11 model drv", {6'd0, drive_str}, {6'd0, m_drv[6:5]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual %0d expected <20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_n = 0; cmd_valid = 1; cmd_op = op; step();
    cmd_valid = 0; cs_n = 1; step();
  endtask

  task automatic open_get(input logic [7:0] a);
    cs_n = 0; cmd_valid = 1; cmd_op = 8'h0F; step();
    cmd_valid = 0; addr_valid = 1; addr_byte = a; step();
    addr_valid = 0;
  endtask

  task automatic get_feat(input logic [7:0] a, input logic [7:0] exp, input string tag);
    open_get(a);
    @(negedge clk);
    check(tag, rd_data, exp);
    check(tag, {7'd0, rd_valid}, 8'd1);
    step(); cs_n = 1; step();
  endtask

  task automatic set_feat(input logic [7:0] a, input logic [7:0] d, input bit extra);
    cs_n = 0; cmd_valid = 1; cmd_op = 8'h1F; step();
    cmd_valid = 0; addr_valid = 1; addr_byte = a; step();
    addr_valid = 0; wr_valid = 1; wr_data = d; step();
    if (extra) begin
      wr_data = ~d; step();
    end
    wr_valid = 0; cs_n = 1; step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();

    // R1 reset state
    check("R1 wel", {7'd0, wel}, 8'd0);
    check("R1 ecc_en", {7'd0, cfg_ecc_en}, 8'd1);
    get_feat(8'hA0, 8'h00, "R1 prot");
    get_feat(8'hB0, 8'h10, "R1 cfg");
    get_feat(8'hC0, 8'h00, "R1 stat");
    get_feat(8'hD0, 8'h00, "R1 drv");

    // R6 protection lock, R4 masking
    set_feat(8'hA0, 8'hFF, 0);
    get_feat(8'hA0, 8'hBE, "R4 R6 prot masked write");
    check("R11 prot_bp", {5'd0, prot_bp}, 8'd7);
    wp_n = 0;
    set_feat(8'hA0, 8'h00, 0);
    get_feat(8'hA0, 8'hBE, "R6 locked write ignored");
    wp_n = 1;
    set_feat(8'hA0, 8'h00, 0);
    get_feat(8'hA0, 8'h00, "R6 wp high writes");
    wp_n = 0;
    set_feat(8'hA0, 8'h3C, 0);
    get_feat(8'hA0, 8'h3C, "R6 lock bit clear writes");
    wp_n = 1;

    // R4 one byte per transaction, reserved bits
    set_feat(8'hB0, 8'hFF, 1);
    get_feat(8'hB0, 8'hD1, "R4 cfg first byte only");
    check("R11 qe", {7'd0, cfg_qe}, 8'd1);
    set_feat(8'hD0, 8'hFF, 0);
    get_feat(8'hD0, 8'h60, "R4 drv mask");
    check("R11 drive", {6'd0, drive_str}, 8'd3);

    // R2 unknown address
    set_feat(8'h90, 8'hFF, 0);
    get_feat(8'h90, 8'h00, "R2 unknown read");
    get_feat(8'hA0, 8'h3C, "R2 prot untouched");
    get_feat(8'hB0, 8'hD1, "R2 cfg untouched");

    // R7 latch commands
    cmd(8'h06);
    check("R7 set", {7'd0, wel}, 8'd1);
    get_feat(8'hC0, 8'h02, "R7 status bit1");
    cmd(8'h04);
    check("R7 clear", {7'd0, wel}, 8'd0);

    // R8 completion clears, wins over set
    cs_n = 0; cmd_valid = 1; cmd_op = 8'h06; op_done = 1; step();
    cmd_valid = 0; op_done = 0; cs_n = 1; step();
    check("R8 clear wins", {7'd0, wel}, 8'd0);
    cmd(8'h06);
    op_done = 1; step(); op_done = 0; step();
    check("R8 done clears", {7'd0, wel}, 8'd0);

    // R10 status capture
    pfail_set = 1; efail_set = 1; ecc_valid = 1; ecc_code = 3'b101; step();
    pfail_set = 0; efail_set = 0; ecc_valid = 0; step();
    get_feat(8'hC0, 8'h5C, "R10 status fields");
    cmd(8'h06);

    // R5 status read-only
    set_feat(8'hC0, 8'hFF, 0);
    get_feat(8'hC0, 8'h5E, "R5 status unchanged");

    // R3 live update and termination
    open_get(8'hC0);
    @(negedge clk); check("R3 live idle", rd_data, 8'h5E);
    step(); array_busy = 1;
    @(negedge clk); check("R3 live busy", rd_data, 8'h5F);
    step(); array_busy = 0;
    @(negedge clk); check("R3 live idle again", rd_data, 8'h5E);
    step(); cs_n = 1; step();
    check("R3 rd_valid drops", {7'd0, rd_valid}, 8'd0);

    // R9 soft reset while busy, then idle
    array_busy = 1;
    cmd(8'hFF);
    check("R9 busy wel cleared", {7'd0, wel}, 8'd0);
    get_feat(8'hC0, 8'h5D, "R9 busy keeps fails");
    array_busy = 0;
    cmd(8'hFF);
    get_feat(8'hC0, 8'h00, "R9 idle clears");
    get_feat(8'hA0, 8'h3C, "R9 prot survives");
    get_feat(8'hB0, 8'hD1, "R9 cfg survives");
    get_feat(8'hD0, 8'h60, "R9 drv survives");

    repeat (2) step();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule